// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the general-purpose integer registers of a 32-bit RISC core whose register names slide over a larger physical bank. It has two combinational read ports and one clocked write port, each addressed by a 5-bit register number. A window pointer picks which slice of the bank the upper 24 register numbers reach. Register numbers 0 to 7 are globals that every window shares. Numbers 8 to 15 are the outgoing registers of the current window. Numbers 16 to 23 are its private locals. Numbers 24 to 31 are its incoming registers, which are physically the outgoing registers of the window one step above it.

A call-entry step (save) moves the pointer one window down and a return step (restore) moves it one window up. Both wrap modulo the window count. Either step adds the two read operands, taken in the old window, and writes the sum to the destination register in the new window, so a callee finds its caller's outgoing values on its own incoming registers. An invalid-window mask marks windows that must not be entered. A step that would land on a marked window raises a same-cycle overflow (save) or underflow (restore) flag, and it changes neither the pointer nor any register.

Top module: `window_regfile`

## Requirements
- R1: After reset the window pointer is 0, and both trap flags are low.
- R2: Register 0 reads as zero on both ports in every window. A write to register 0 changes nothing.
- R3: Registers 1 to 7 are shared: a value written in one window is read back unchanged in every other window.
- R4: Registers 16 to 23 are private to each window. A write to one of them in window w is not visible in any other window.
- R5: Register 24+k in window w is the same storage as register 8+k in window (w+1) mod NUM_WIN, for k = 0 to 7.
- R6: A save sets the pointer to (p-1) mod NUM_WIN and a restore sets it to (p+1) mod NUM_WIN; the new value is visible after the clock edge. When both requests are high, the save is performed and the restore is ignored. With no request, the pointer holds.
- R7: On a save or restore that is carried out, the sum rdDataA+rdDataB, read in the old window, is written to wrAddr as mapped in the new window. wrEn and wrData are ignored during that step.
- R8: A save whose target window has its invalidMask bit set raises overflowFlag in the same cycle. The pointer and every register stay unchanged, including a write requested through wrEn.
- R9: A restore whose target window has its invalidMask bit set raises underflowFlag in the same cycle. The pointer and every register stay unchanged, including a write requested through wrEn.
- R10: A read of the register being written in the same cycle returns the old value. The new value is read from the next cycle onward.
- R11: With no save or restore requested and wrEn high, wrData is written to wrAddr as mapped in the current window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the window pointer |
| rdAddrA | input | 5 | Register number for read port A |
| rdDataA | output | DATA_W | Read port A data, combinational |
| rdAddrB | input | 5 | Register number for read port B |
| rdDataB | output | DATA_W | Read port B data, combinational |
| wrEn | input | 1 | Plain write enable |
| wrAddr | input | 5 | Destination register number |
| wrData | input | DATA_W | Plain write data |
| saveReq | input | 1 | Request a window step down with operand sum |
| restoreReq | input | 1 | Request a window step up with operand sum |
| invalidMask | input | NUM_WIN | One bit per window; set means that window may not be entered |
| winPtr | output | $clog2(NUM_WIN) | Current window pointer |
| overflowFlag | output | 1 | Save blocked by the mask, same cycle |
| underflowFlag | output | 1 | Restore blocked by the mask, same cycle |

## Verification
The bench builds the block with NUM_WIN = 4. With that value every window can be reached and every one of the 32 register numbers can be written and read back in each window, which covers 128 mappings. The small count also brings both wrap points of the pointer (0 to 3 on a save, 3 to 0 on a restore) within a few steps. It shows that the incoming registers of window 3 land on the outgoing registers of window 0. Blocked steps are tested with single mask bits next to the current window, and the bench then reads back the registers the blocked step would have written.

// File: rtl/winrf_pkg.sv
package winrf_pkg;
  localparam int GLOBAL_N  = 8;
  localparam int WIN_SLAB  = 16;
  localparam int REG_NUM_W = 5;

  typedef struct packed {
    logic wrCommit;
    logic wrSum;
    logic winMove;
  } wrfStrobe_t;
endpackage

// File: rtl/winrf_ctrl.sv
module winrf_ctrl
  import winrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int CWP_W   = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               saveReq,
  input  logic               restoreReq,
  input  logic               wrEn,
  input  logic [NUM_WIN-1:0] invalidMask,
  output logic [CWP_W-1:0]   curWin,
  output logic [CWP_W-1:0]   nextWin,
  output wrfStrobe_t         strobe,
  output logic               overflowFlag,
  output logic               underflowFlag
);
  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NUM_WIN - 1);

  logic [CWP_W-1:0] downWin;
  logic [CWP_W-1:0] upWin;
  logic moveDown;
  logic moveUp;
  logic goDown;
  logic goUp;

  always_comb begin
    downWin = (curWin == '0) ? LAST_WIN : curWin - CWP_W'(1);
    upWin   = (curWin == LAST_WIN) ? '0 : curWin + CWP_W'(1);
  end

  // Save wins over restore when both are requested.
  assign moveDown = saveReq;
  assign moveUp   = restoreReq && !saveReq;

  assign overflowFlag  = moveDown && invalidMask[downWin];
  assign underflowFlag = moveUp && invalidMask[upWin];

  assign goDown = moveDown && !overflowFlag;
  assign goUp   = moveUp && !underflowFlag;

  always_comb begin
    if (goDown)    nextWin = downWin;
    else if (goUp) nextWin = upWin;
    else           nextWin = curWin;
  end

  always_comb begin
    strobe.winMove  = goDown || goUp;
    strobe.wrSum    = goDown || goUp;
    strobe.wrCommit = (goDown || goUp) || (wrEn && !saveReq && !restoreReq);
  end

  always_ff @(posedge clk) begin
    if (!rstN) curWin <= '0;
    else       curWin <= nextWin;
  end

  // R6: pointer never leaves the implemented range
  p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    curWin <= LAST_WIN);

  // R6: an accepted save steps down with wrap
  p_save_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (saveReq && !overflowFlag) |=>
      curWin == (($past(curWin) == '0) ? LAST_WIN : $past(curWin) - CWP_W'(1)));

  // R6: an accepted restore steps up with wrap
  p_restore_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (restoreReq && !saveReq && !underflowFlag) |=>
      curWin == (($past(curWin) == LAST_WIN) ? '0 : $past(curWin) + CWP_W'(1)));

  // R6: idle cycles keep the pointer
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!saveReq && !restoreReq) |=> $stable(curWin));

  // R8: blocked save keeps the pointer
  p_overflow_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> $stable(curWin));

  // R9: blocked restore keeps the pointer
  p_underflow_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    underflowFlag |=> $stable(curWin));

  // R8: never both trap flags at once
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(overflowFlag && underflowFlag));
endmodule

// File: rtl/winrf_datapath.sv
module winrf_datapath
  import winrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int CWP_W   = $clog2(NUM_WIN)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CWP_W-1:0]     curWin,
  input  logic [CWP_W-1:0]     nextWin,
  input  wrfStrobe_t           strobe,
  input  logic [REG_NUM_W-1:0] rdAddrA,
  input  logic [REG_NUM_W-1:0] rdAddrB,
  output logic [DATA_W-1:0]    rdDataA,
  output logic [DATA_W-1:0]    rdDataB,
  input  logic [REG_NUM_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]    wrData
);
  localparam int PHYS_N   = GLOBAL_N + WIN_SLAB * NUM_WIN;
  localparam int IDX_W    = $clog2(PHYS_N);
  localparam int RD_PORTS = 2;
  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NUM_WIN - 1);

  logic [DATA_W-1:0] regMem [PHYS_N];

  // Register number to flat storage index for a given window.
  // Slab of window w: 8 outgoing then 8 local; incoming map to the slab above.
  function automatic logic [IDX_W-1:0] physIdx(input logic [CWP_W-1:0] win,
                                               input logic [REG_NUM_W-1:0] regNum);
    logic [CWP_W-1:0] aboveWin;
    int flat;
    aboveWin = (win == LAST_WIN) ? '0 : win + CWP_W'(1);
    case (regNum[4:3])
      2'b00:   flat = int'(regNum);
      2'b11:   flat = GLOBAL_N + WIN_SLAB * int'(aboveWin) + int'(regNum[2:0]);
      default: flat = GLOBAL_N + WIN_SLAB * int'(win) + int'(regNum) - 8;
    endcase
    return IDX_W'(flat);
  endfunction

  logic [REG_NUM_W-1:0] rdAddr [RD_PORTS];
  logic [DATA_W-1:0]    rdData [RD_PORTS];

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    logic [IDX_W-1:0] rdIdx;
    assign rdIdx     = physIdx(curWin, rdAddr[p]);
    assign rdData[p] = (rdAddr[p] == '0) ? '0 : regMem[rdIdx];
  end

  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];

  logic [DATA_W-1:0] sumVal;
  logic [DATA_W-1:0] wrVal;
  logic [IDX_W-1:0]  wrIdx;

  assign sumVal = rdData[0] + rdData[1];
  assign wrVal  = strobe.wrSum ? sumVal : wrData;
  assign wrIdx  = physIdx(nextWin, wrAddr);

  always_ff @(posedge clk) begin
    if (strobe.wrCommit && (wrAddr != '0)) regMem[wrIdx] <= wrVal;
  end

  // R7: an accepted window step always lands in a different window
  p_move_new_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.winMove |-> (nextWin != curWin));

  // R11: a committed write addresses implemented storage
  p_write_slot_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCommit |-> (int'(wrIdx) < PHYS_N));

  // R8: without an accepted step the write window is the current one
  p_stay_window_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.winMove |-> (nextWin == curWin));
endmodule

// File: rtl/window_regfile.sv
module window_regfile
  import winrf_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  localparam int CWP_W  = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [4:0]         rdAddrA,
  output logic [DATA_W-1:0]  rdDataA,
  input  logic [4:0]         rdAddrB,
  output logic [DATA_W-1:0]  rdDataB,
  input  logic               wrEn,
  input  logic [4:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               saveReq,
  input  logic               restoreReq,
  input  logic [NUM_WIN-1:0] invalidMask,
  output logic [CWP_W-1:0]   winPtr,
  output logic               overflowFlag,
  output logic               underflowFlag
);
  wrfStrobe_t       strobe;
  logic [CWP_W-1:0] curWin;
  logic [CWP_W-1:0] nextWin;

  winrf_ctrl #(.NUM_WIN(NUM_WIN), .CWP_W(CWP_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .saveReq      (saveReq),
    .restoreReq   (restoreReq),
    .wrEn         (wrEn),
    .invalidMask  (invalidMask),
    .curWin       (curWin),
    .nextWin      (nextWin),
    .strobe       (strobe),
    .overflowFlag (overflowFlag),
    .underflowFlag(underflowFlag)
  );

  winrf_datapath #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .CWP_W(CWP_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .curWin (curWin),
    .nextWin(nextWin),
    .strobe (strobe),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB),
    .wrAddr (wrAddr),
    .wrData (wrData)
  );

  assign winPtr = curWin;
endmodule

// File: tb/window_regfile_bench.sv
module window_regfile_bench;
  localparam int NW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [4:0]    rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [DW-1:0] rdDataA, rdDataB, wrData = '0;
  logic          wrEn = 1'b0, saveReq = 1'b0, restoreReq = 1'b0;
  logic [NW-1:0] invalidMask = '0;
  logic [1:0]    winPtr;
  logic          overflowFlag, underflowFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [DW-1:0] mG [8];
  logic [DW-1:0] mO [NW][8];
  logic [DW-1:0] mL [NW][8];
  int mWin = 0;

  always #4 clk = ~clk;

  window_regfile #(.NUM_WIN(NW), .DATA_W(DW)) u_window_regfile (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .saveReq(saveReq), .restoreReq(restoreReq),
    .invalidMask(invalidMask), .winPtr(winPtr),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  function automatic logic [DW-1:0] modelGet(int w, int r);
    if (r == 0)  return '0;
    if (r < 8)   return mG[r];
    if (r < 16)  return mO[w][r-8];
    if (r < 24)  return mL[w][r-16];
    return mO[(w+1)%NW][r-24];
  endfunction

  task automatic modelSet(int w, int r, logic [DW-1:0] v);
    if (r == 0)      return;
    else if (r < 8)  mG[r] = v;
    else if (r < 16) mO[w][r-8] = v;
    else if (r < 24) mL[w][r-16] = v;
    else             mO[(w+1)%NW][r-24] = v;
  endtask

  function automatic string regReq(int r);
    if (r == 0)  return "R2";
    if (r < 8)   return "R3";
    if (r < 16)  return "R11";
    if (r < 24)  return "R4";
    return "R5";
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic doWrite(int r, logic [DW-1:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'(r); wrData = v;
    saveReq = 1'b0; restoreReq = 1'b0;
    @(posedge clk); #1;
    wrEn = 1'b0;
    modelSet(mWin, r, v);
  endtask

  task automatic readChk(int ra, int rb);
    @(negedge clk);
    rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    #2;
    chk(rdDataA == modelGet(mWin, ra), regReq(ra), rdDataA, modelGet(mWin, ra));
    chk(rdDataB == modelGet(mWin, rb), regReq(rb), rdDataB, modelGet(mWin, rb));
  endtask

  task automatic doMove(bit sv, bit rs, int a, int b, int d,
                        logic [NW-1:0] mask, bit expOv, bit expUn, string req);
    logic [DW-1:0] sum;
    int target;
    @(negedge clk);
    rdAddrA = 5'(a); rdAddrB = 5'(b); wrAddr = 5'(d);
    wrEn = 1'b1; wrData = 32'hDEAD_BEEF;
    saveReq = sv; restoreReq = rs; invalidMask = mask;
    #2;
    chk(overflowFlag == expOv, req, 32'(overflowFlag), 32'(expOv));
    chk(underflowFlag == expUn, req, 32'(underflowFlag), 32'(expUn));
    sum = modelGet(mWin, a) + modelGet(mWin, b);
    target = sv ? (mWin + NW - 1) % NW : (mWin + 1) % NW;
    @(posedge clk); #1;
    saveReq = 1'b0; restoreReq = 1'b0; wrEn = 1'b0; invalidMask = '0;
    if (!expOv && !expUn) begin
      mWin = target;
      modelSet(mWin, d, sum);
    end
    chk(winPtr == 2'(mWin), req, 32'(winPtr), 32'(mWin));
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(winPtr == 2'd0, "R1", 32'(winPtr), 0);
    chk(!overflowFlag && !underflowFlag, "R1", 32'({overflowFlag, underflowFlag}), 0);
    @(negedge clk); rstN = 1'b1;

    // Fill every register number in every window, stepping up with restores.
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < 32; r++) doWrite(r, 32'hA000_0000 | (w << 8) | r);
      doMove(1'b0, 1'b1, 0, 0, 0, '0, 1'b0, 1'b0, "R6");  // wraps 3 -> 0 at the end
    end

    // Read back everything in every window (R2 R3 R4 R5 R11).
    for (int w = 0; w < NW; w++) begin
      for (int r = 0; r < 32; r++) readChk(r, 31 - r);
      doMove(1'b0, 1'b1, 0, 0, 0, '0, 1'b0, 1'b0, "R6");
    end

    // R7: save from window 0 wraps to 3; sum of old-window operands lands in new window
    doMove(1'b1, 1'b0, 9, 17, 26, '0, 1'b0, 1'b0, "R7");
    chk(winPtr == 2'd3, "R6", 32'(winPtr), 3);
    readChk(26, 9);
    // R6: both requests -> save wins, 3 -> 2
    doMove(1'b1, 1'b1, 1, 2, 20, '0, 1'b0, 1'b0, "R6");
    chk(winPtr == 2'd2, "R6", 32'(winPtr), 2);
    readChk(20, 0);
    doMove(1'b0, 1'b1, 0, 0, 0, '0, 1'b0, 1'b0, "R6");
    doMove(1'b0, 1'b1, 0, 0, 0, '0, 1'b0, 1'b0, "R6");
    chk(winPtr == 2'd0, "R6", 32'(winPtr), 0);
    // R5: caller's out r10 holds what callee wrote to its r26
    readChk(10, 26);

    // R8: blocked save from window 0 (target 3), destination r26 of window 3 = r10 of window 0
    doMove(1'b1, 1'b0, 9, 17, 26, 4'b1000, 1'b1, 1'b0, "R8");
    readChk(10, 9);
    // R9: blocked restore from window 0 (target 1), destination r8 of window 1 = r24 of window 0
    doMove(1'b0, 1'b1, 3, 4, 8, 4'b0010, 1'b0, 1'b1, "R9");
    readChk(24, 3);
    // R2: write to r0 discarded
    doWrite(0, 32'h1234_5678);
    readChk(0, 0);

    // R10: read during write returns old value, new value next cycle
    @(negedge clk);
    rdAddrA = 5'd5; rdAddrB = 5'd5;
    wrEn = 1'b1; wrAddr = 5'd5; wrData = 32'h5A5A_0005;
    #2;
    chk(rdDataA == mG[5], "R10", rdDataA, mG[5]);
    @(posedge clk); #1;
    wrEn = 1'b0; mG[5] = 32'h5A5A_0005;
    chk(rdDataA == 32'h5A5A_0005, "R10", rdDataA, 32'h5A5A_0005);
    chk(rdDataB == 32'h5A5A_0005, "R10", rdDataB, 32'h5A5A_0005);

    finishRun();
  end
endmodule